// File: doc/BRIEF.md
# Power-down and wake-up sequencer

This block sequences a chip's entry into and exit from power-down. Software programs it through one 32-bit control/status word. Three bits in that word enable the oscillators. Other bits arm power-down and choose whether entry also waits for the CPU's wait-for-interrupt sleep indication. One bit enables a clock-settling delay after wake, another enables the wake interrupt, and a write-one-to-clear flag reports wake.

While powered down, the block forces the crystal and fast RC oscillator enables low and stops the system clock. The slow RC oscillator is left as software set it. A GPIO or UART wake request ends power-down. If the delay is enabled, the system clock stays off for a settling window whose length depends on the current clock source: 4096 cycles for the crystal, 256 for the fast RC oscillator. The clock then resumes. On wake the arm bit clears itself, and the wake flag and interrupt are raised when the interrupt is enabled.

Top module: `pdn_ctrl`

## Requirements
- R1: Word bits 0, 1 and 2 enable the crystal, fast RC and slow RC oscillators (1 = on). They read back as written, and outside power-down they drive `xtal_en_o`, `hirc_en_o` and `lirc_en_o` directly.
- R2: After reset the word reads `cfg_xtal_default` in bit 0 and zero elsewhere, `sysclk_en` is 1 and `wake_irq` is 0.
- R3: Writing bit 7 (arm) = 1 with bit 8 (wait-for-CPU) = 0 stops the system clock from the first clock edge after the write cycle.
- R4: With bits 7 and 8 both 1, the system clock keeps running until `cpu_wfi` is sampled high, and it stops on that same edge.
- R5: While powered down, `sysclk_en`, `xtal_en_o` and `hirc_en_o` are 0 and `lirc_en_o` still follows bit 2.
- R6: A wake request sampled in power-down holds `sysclk_en` low for exactly 4096 further cycles when bit 4 = 1 and `clk_src_xtal` = 1, for 256 cycles when bit 4 = 1 and `clk_src_xtal` = 0, and for 0 cycles when bit 4 = 0.
- R7: Bit 7 reads 1 during power-down and reads 0 once wake has occurred.
- R8: Bit 6 (wake flag) is set by a wake only when bit 5 = 1. Writing 1 to bit 6 clears it, and writing 0 there leaves it unchanged.
- R9: `wake_irq` is 1 exactly while bit 6 and bit 5 are both 1.
- R10: Bits 3 and 9 to 31 always read 0, whatever is written.
- R11: Wake requests that arrive outside power-down change neither the word nor any output.
- R12: Clearing bit 7 while waiting for the CPU cancels the pending power-down, and the clock keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock of the controller |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_xtal_default | input | 1 | Reset value of the crystal enable |
| clk_src_xtal | input | 1 | 1 = system clock runs from the crystal, 0 = from the fast RC |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current control/status word |
| cpu_wfi | input | 1 | CPU is in wait-for-interrupt sleep |
| wake_gpio | input | 1 | Wake request from GPIO |
| wake_uart | input | 1 | Wake request from UART |
| xtal_en_o | output | 1 | Crystal oscillator enable |
| hirc_en_o | output | 1 | Fast RC oscillator enable |
| lirc_en_o | output | 1 | Slow RC oscillator enable |
| sysclk_en | output | 1 | System clock enable |
| wake_irq | output | 1 | Wake interrupt |

## Verification
The sweep covers every combination of the wait-for-CPU mode, the delay enable, the interrupt enable, the clock source and the wake pin. This separates immediate entry from CPU-qualified entry, and the 4096, 256 and zero cycle settling windows from one another. It also shows whether the flag and interrupt depend on the enable rather than on the wake itself. The bench counts the clock-off cycles after each wake and compares that count with the number expected for the mode. Wake pulses sent while running or while waiting for the CPU, together with writes of all ones and a cancelled arm, show whether events and bits that must be ignored leak into the word or the outputs.

// File: rtl/pdn_pkg.sv
// Package: shared state encoding and control-word bit positions for the
// power-down sequencer. Assumes a 32-bit control word.
package pdn_pkg;
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WAIT_CPU = 3'd1,
        ST_PWRDN    = 3'd2,
        ST_WAKE_DLY = 3'd3,
        ST_RUN      = 3'd4
    } pdn_state_e;

    localparam int B_XTAL   = 0;
    localparam int B_HIRC   = 1;
    localparam int B_LIRC   = 2;
    localparam int B_DLY    = 4;
    localparam int B_IRQEN  = 5;
    localparam int B_FLAG   = 6;
    localparam int B_ARM    = 7;
    localparam int B_WAITC  = 8;
endpackage

// File: rtl/pdn_regs.sv
// Module: control/status word of the sequencer.
// Holds the writable fields and the write-one-to-clear wake flag.
// Assumes wake_hit is a single-cycle pulse from the sequencer. Hardware
// updates (arm clear, flag set) take priority over a write in the same cycle.
module pdn_regs
    import pdn_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_xtal_default,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          wake_hit,
    output logic [DW-1:0] rd_data,
    output logic          f_xtal,
    output logic          f_hirc,
    output logic          f_lirc,
    output logic          f_dly,
    output logic          f_irqen,
    output logic          f_flag,
    output logic          f_arm,
    output logic          f_waitc
);
    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[DW-1:B_WAITC+1], wr_data[3]};

    // Field storage: software writes, then hardware wake side effects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_xtal  <= cfg_xtal_default;
            f_hirc  <= 1'b0;
            f_lirc  <= 1'b0;
            f_dly   <= 1'b0;
            f_irqen <= 1'b0;
            f_flag  <= 1'b0;
            f_arm   <= 1'b0;
            f_waitc <= 1'b0;
        end else begin
            if (wr_en) begin
                f_xtal  <= wr_data[B_XTAL];
                f_hirc  <= wr_data[B_HIRC];
                f_lirc  <= wr_data[B_LIRC];
                f_dly   <= wr_data[B_DLY];
                f_irqen <= wr_data[B_IRQEN];
                f_arm   <= wr_data[B_ARM];
                f_waitc <= wr_data[B_WAITC];
                if (wr_data[B_FLAG]) f_flag <= 1'b0;
            end
            if (wake_hit) begin
                f_arm <= 1'b0;
                if (f_irqen) f_flag <= 1'b1;
            end
        end
    end

    // Read-back assembly; unused positions are tied to zero.
    always_comb begin
        rd_data          = '0;
        rd_data[B_XTAL]  = f_xtal;
        rd_data[B_HIRC]  = f_hirc;
        rd_data[B_LIRC]  = f_lirc;
        rd_data[B_DLY]   = f_dly;
        rd_data[B_IRQEN] = f_irqen;
        rd_data[B_FLAG]  = f_flag;
        rd_data[B_ARM]   = f_arm;
        rd_data[B_WAITC] = f_waitc;
    end

    // The arm bit is gone one cycle after a wake.
    assert_arm_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_hit |=> !f_arm);

    // The flag only rises from a wake while the interrupt is enabled.
    assert_flag_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(f_flag) |-> ($past(f_irqen) && $past(wake_hit)));
endmodule

// File: rtl/pdn_fsm.sv
// Module: power-down state machine with the post-wake settling counter.
// Assumes wake requests are synchronous to clk. Delay lengths are sampled
// from the clock source at the wake edge.
module pdn_fsm
    import pdn_pkg::*;
#(
    parameter int XTAL_DLY = 4096,
    parameter int RC_DLY   = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm,
    input  logic       wait_cpu,
    input  logic       dly_en,
    input  logic       src_xtal,
    input  logic       cpu_wfi,
    input  logic       wake_req,
    output pdn_state_e state,
    output logic       wake_hit,
    output logic       sysclk_en
);
    localparam int MAXD = (XTAL_DLY > RC_DLY) ? XTAL_DLY : RC_DLY;
    localparam int CW   = (MAXD > 2) ? $clog2(MAXD) : 1;
    localparam logic [CW-1:0] XLOAD = CW'(XTAL_DLY - 1);
    localparam logic [CW-1:0] RLOAD = CW'(RC_DLY - 1);

    pdn_state_e      nxt;
    logic [CW-1:0]   cnt;

    assign wake_hit  = (state == ST_PWRDN) && wake_req;
    assign sysclk_en = (state == ST_IDLE) || (state == ST_WAIT_CPU) || (state == ST_RUN);

    // Next-state selection.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE, ST_RUN:
                if (arm) nxt = wait_cpu ? ST_WAIT_CPU : ST_PWRDN;
            ST_WAIT_CPU:
                if (!arm)                     nxt = ST_IDLE;
                else if (!wait_cpu || cpu_wfi) nxt = ST_PWRDN;
            ST_PWRDN:
                if (wake_req) nxt = dly_en ? ST_WAKE_DLY : ST_RUN;
            ST_WAKE_DLY:
                if (cnt == '0) nxt = ST_RUN;
            default: nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Settling counter: loaded on wake, counts down while delaying.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   cnt <= '0;
        else if (wake_hit)                            cnt <= src_xtal ? XLOAD : RLOAD;
        else if (state == ST_WAKE_DLY && cnt != '0)   cnt <= cnt - 1'b1;
    end

    // Without an armed request the chip never powers down.
    assert_no_arm_no_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE || state == ST_RUN) && !arm) |=> (state != ST_PWRDN));

    // The CPU-qualified wait holds until the CPU sleeps.
    assert_wait_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_CPU && arm && wait_cpu && !cpu_wfi) |=> (state == ST_WAIT_CPU));

    // An expired settling counter releases the clock next cycle.
    assert_delay_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAKE_DLY && cnt == '0) |=> sysclk_en);
endmodule

// File: rtl/pdn_ctrl.sv
// Module: top of the power-down sequencer. Joins the control word and the
// state machine, and gates the oscillator enables while powered down.
// Assumes all inputs are synchronous to clk; reset is synchronous, active low.
module pdn_ctrl
    import pdn_pkg::*;
#(
    parameter int DW       = 32,
    parameter int XTAL_DLY = 4096,
    parameter int RC_DLY   = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_xtal_default,
    input  logic          clk_src_xtal,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    input  logic          cpu_wfi,
    input  logic          wake_gpio,
    input  logic          wake_uart,
    output logic          xtal_en_o,
    output logic          hirc_en_o,
    output logic          lirc_en_o,
    output logic          sysclk_en,
    output logic          wake_irq
);
    logic f_xtal, f_hirc, f_lirc, f_dly, f_irqen, f_flag, f_arm, f_waitc;
    logic wake_hit;
    logic in_pd;
    pdn_state_e state;

    pdn_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_xtal_default(cfg_xtal_default),
        .wr_en(wr_en), .wr_data(wr_data), .wake_hit(wake_hit), .rd_data(rd_data),
        .f_xtal(f_xtal), .f_hirc(f_hirc), .f_lirc(f_lirc), .f_dly(f_dly),
        .f_irqen(f_irqen), .f_flag(f_flag), .f_arm(f_arm), .f_waitc(f_waitc)
    );

    pdn_fsm #(.XTAL_DLY(XTAL_DLY), .RC_DLY(RC_DLY)) u_fsm (
        .clk(clk), .rst_n(rst_n), .arm(f_arm), .wait_cpu(f_waitc), .dly_en(f_dly),
        .src_xtal(clk_src_xtal), .cpu_wfi(cpu_wfi), .wake_req(wake_gpio | wake_uart),
        .state(state), .wake_hit(wake_hit), .sysclk_en(sysclk_en)
    );

    // Output gating: fast oscillators off only in the powered-down state.
    assign in_pd     = (state == ST_PWRDN);
    assign xtal_en_o = f_xtal & ~in_pd;
    assign hirc_en_o = f_hirc & ~in_pd;
    assign lirc_en_o = f_lirc;
    assign wake_irq  = f_flag & f_irqen;

    // With the clock stopped and no settling under way, fast oscillators are off.
    assert_pd_gates_osc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sysclk_en && state != ST_WAKE_DLY) |-> (!xtal_en_o && !hirc_en_o));

    // Clock stop never comes from a write that left the arm bit clear.
    assert_stop_needs_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sysclk_en) |-> $past(f_arm));
endmodule

// File: tb/tb_pdn_ctrl.sv
module tb_pdn_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_xtal_default = 1'b1;
    logic        clk_src_xtal = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        cpu_wfi = 1'b0, wake_gpio = 1'b0, wake_uart = 1'b0;
    logic        xtal_en_o, hirc_en_o, lirc_en_o, sysclk_en, wake_irq;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pdn_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_xtal_default(cfg_xtal_default),
        .clk_src_xtal(clk_src_xtal), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .cpu_wfi(cpu_wfi), .wake_gpio(wake_gpio), .wake_uart(wake_uart),
        .xtal_en_o(xtal_en_o), .hirc_en_o(hirc_en_o), .lirc_en_o(lirc_en_o),
        .sysclk_en(sysclk_en), .wake_irq(wake_irq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R2: reset with crystal default selected, then deselected
        repeat (3) @(negedge clk);
        chk(rd_data == 32'h1, "R2 reset word cfg=1", rd_data, 32'h1);
        chk(sysclk_en && xtal_en_o && !wake_irq, "R2 reset outputs", {sysclk_en, xtal_en_o, wake_irq}, 3'b110);
        cfg_xtal_default = 1'b0;
        repeat (2) @(negedge clk);
        chk(rd_data == 32'h0 && !xtal_en_o, "R2 reset word cfg=0", rd_data, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 and R4: all ones arms with CPU wait; reserved bits stay zero
        wr(32'hFFFF_FFFF);
        chk(rd_data == 32'h1B7, "R10 reserved bits read zero", rd_data, 32'h1B7);
        repeat (3) begin
            @(negedge clk);
            chk(sysclk_en == 1'b1, "R4 clock runs until cpu_wfi", sysclk_en, 1);
        end
        // R12: cancel before the CPU sleeps
        wr(32'h0);
        chk(sysclk_en == 1'b1, "R12 cancel keeps clock", sysclk_en, 1);
        repeat (3) @(negedge clk);
        cpu_wfi = 1'b1;
        @(negedge clk); cpu_wfi = 1'b0;
        chk(sysclk_en == 1'b1 && rd_data == 32'h0, "R12 cancelled arm ignores cpu_wfi", rd_data, 0);

        // R1: oscillator enables follow the word
        for (int v = 0; v < 8; v++) begin
            wr(32'(v));
            chk(rd_data == 32'(v), "R1 readback", rd_data, 32'(v));
            chk({lirc_en_o, hirc_en_o, xtal_en_o} == 3'(v), "R1 enable outputs",
                {lirc_en_o, hirc_en_o, xtal_en_o}, 32'(v));
        end

        // R11: wake while running is ignored
        wr(32'h27);
        wake_gpio = 1'b1; @(negedge clk);
        wake_gpio = 1'b0; wake_uart = 1'b1; @(negedge clk);
        wake_uart = 1'b0; @(negedge clk);
        chk(rd_data == 32'h27 && !wake_irq && sysclk_en, "R11 wake outside power-down", rd_data, 32'h27);

        // Sweep: wait mode, delay, irq enable, clock source, wake pin
        for (int i = 0; i < 32; i++) begin
            automatic bit wc = i[0], dl = i[1], ie = i[2], sx = i[3], ua = i[4];
            automatic logic [31:0] base = 32'h7 | (32'(dl) << 4) | (32'(ie) << 5) | (32'(wc) << 8);
            automatic int expn = dl ? (sx ? 4096 : 256) : 0;
            automatic int cnt = 0;
            clk_src_xtal = sx;
            wr(base | 32'h80);
            chk(rd_data == (base | 32'h80), "R7 arm readback", rd_data, base | 32'h80);
            if (wc) begin
                repeat (2) begin
                    chk(sysclk_en == 1'b1, "R4 waiting for CPU", sysclk_en, 1);
                    @(negedge clk);
                end
                wake_gpio = 1'b1; @(negedge clk); wake_gpio = 1'b0;
                chk(sysclk_en && rd_data == (base | 32'h80), "R11 wake during CPU wait", rd_data, base | 32'h80);
                cpu_wfi = 1'b1; @(negedge clk); cpu_wfi = 1'b0;
                chk(sysclk_en == 1'b0, "R4 stop on cpu_wfi", sysclk_en, 0);
            end else begin
                @(negedge clk);
                chk(sysclk_en == 1'b0, "R3 immediate stop", sysclk_en, 0);
            end
            chk(!xtal_en_o && !hirc_en_o && lirc_en_o, "R5 oscillator gating",
                {lirc_en_o, hirc_en_o, xtal_en_o}, 3'b100);
            repeat (4) @(negedge clk);
            chk(!sysclk_en && rd_data[7], "R7 arm held in power-down", rd_data, base | 32'h80);
            if (ua) wake_uart = 1'b1; else wake_gpio = 1'b1;
            @(negedge clk);
            wake_uart = 1'b0; wake_gpio = 1'b0;
            while (!sysclk_en && cnt < 5000) begin
                cnt++;
                @(negedge clk);
            end
            chk(cnt == expn, "R6 settling length", cnt, expn);
            chk(rd_data[7] == 1'b0, "R7 arm cleared on wake", rd_data[7], 0);
            chk(rd_data[6] == ie, "R8 flag follows enable", rd_data[6], ie);
            repeat (2) @(negedge clk);
            chk(wake_irq == ie, "R9 interrupt level", wake_irq, ie);
            chk(xtal_en_o && hirc_en_o, "R1 oscillators restored", {hirc_en_o, xtal_en_o}, 3);
            wr(base);
            chk(rd_data[6] == ie, "R8 write 0 keeps flag", rd_data[6], ie);
            wr(base | 32'h40);
            chk(rd_data == base && !wake_irq, "R8 R9 write-one clear", rd_data, base);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule